// File: doc/BRIEF.md
# Firmware Glue Register Block

This block is a small memory-mapped peripheral that gives boot and platform firmware a handful of services that an operating system would not normally touch. Firmware can request a halt and leave an exit code, ask which processor it is running on, ask how many processors are active, drive a chosen level onto one of several interrupt lines, and move single characters through a console input holding register and a console output register.

The bus side is a byte-addressed port with a size qualifier. A request is taken when `bus_valid` is high while `bus_ack` is low. `bus_ack` then rises for exactly one cycle, carrying the read data. Only the low six address bits are decoded, so the register set repeats every 64 bytes.

Two enumerated state machines run the block:
- The bus machine has states `ST_IDLE` and `ST_RESP`. Transition `T_ACCEPT` goes from `ST_IDLE` to `ST_RESP` on a request. Transition `T_DONE` always returns from `ST_RESP` to `ST_IDLE`.
- The halt machine has states `HS_RUN` and `HS_HALTED`. Transition `T_HALT` goes from `HS_RUN` to `HS_HALTED` on a write to the halt register. `HS_HALTED` has no exit except reset.

Top module: `glue_regs_top`

## Requirements
- R1: After reset, `bus_ack`, `halt_req`, `cout_valid` and `cin_pop` are 0. Every `irq_level` line is 0. The output status (offset 0x1A) reads 1, and the input data (offset 0x10) reads 0.
- R2: A request is accepted only when `bus_ack` is low. `bus_ack` is high for exactly the next cycle, with `bus_rdata` valid in that cycle. A request held high during the `bus_ack` cycle is ignored.
- R3: Only `bus_addr[5:0]` is decoded, so an address plus 0x40 reaches the same register.
- R4: A write to offset 0x00 sets `halt_req` from the following cycle, with `halt_code` equal to `bus_wdata[7:0]`. `halt_req` stays set, and later halt writes leave `halt_code` unchanged.
- R5: A read of offset 0x04 returns `bus_cpu_idx`, zero-extended.
- R6: A read of offset 0x0A returns `cfg_cpu_count` when `cfg_count_valid` is 1, and returns 1 otherwise.
- R7: A write to offset 0x08 selects line `bus_wdata[7:0]`.
  - For size code 1 (two bytes) or 2 (four bytes), the line takes level `bus_wdata[15:8]`.
  - For size code 0 (one byte), the line takes level 0.
  - A line number of `NUM_IRQ` or more is ignored.
  - Every line holds its level until it is rewritten.
- R8: A read of offset 0x14 samples `cin_ready`.
  - If `cin_ready` is 1, the read returns 1, the input data register loads `cin_char`, and `cin_pop` pulses in the ack cycle.
  - If `cin_ready` is 0, the read returns 0, the input data register clears to 0, and there is no pulse.
- R9: A write to offset 0x18 pulses `cout_valid` for one cycle, in the ack cycle, with `cout_char` equal to `bus_wdata[7:0]`. It also sets the output status to 1. A read of 0x18 returns the last byte written there.
- R10: Writes to offsets 0x10 and 0x1A store `bus_wdata[7:0]`, and that value reads back. A write to 0x14 is accepted but shows nothing, because every status read resamples.
- R11: Reads of unmapped offsets, and of the write-only offsets 0x00 and 0x08, return 0. Writes to unmapped offsets change no register, no line, and no halt state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address, low 6 bits decoded |
| bus_size | input | 2 | 0 = one byte, 1 = two bytes, 2 = four bytes |
| bus_wdata | input | 32 | Write data, low byte first |
| bus_cpu_idx | input | CPU_W | Index of the requesting processor |
| bus_ack | output | 1 | One-cycle response strobe |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| cfg_count_valid | input | 1 | A processor count is configured |
| cfg_cpu_count | input | CPU_W+1 | Configured processor count |
| cin_ready | input | 1 | Console source has a character |
| cin_char | input | 8 | Console source character |
| cin_pop | output | 1 | Character taken from the source |
| cout_valid | output | 1 | Output character strobe |
| cout_char | output | 8 | Output character |
| halt_req | output | 1 | Sticky halt request |
| halt_code | output | 8 | Exit code held with the halt |
| irq_level | output | NUM_IRQ x 8 | Level driven on each interrupt line |

## Verification
The assertions assume that `bus_valid` is low throughout reset. They also assume that a requester holding `bus_valid` into the ack cycle expects that extra cycle to be dropped, not queued. The stimulus drives one request at a time and waits for its ack before the next one. The single exception is a deliberate held request, used to show that it is ignored. Inputs change only on the falling edge, so every sampled value of `cin_ready` and the bus is stable across the accepting edge.

// File: rtl/glue_pkg.sv
package glue_pkg;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 6;

    localparam logic [OFF_W-1:0] OFF_HALT      = 6'h00;
    localparam logic [OFF_W-1:0] OFF_CPU_IDX   = 6'h04;
    localparam logic [OFF_W-1:0] OFF_IRQ       = 6'h08;
    localparam logic [OFF_W-1:0] OFF_CPU_CNT   = 6'h0A;
    localparam logic [OFF_W-1:0] OFF_CIN_DATA  = 6'h10;
    localparam logic [OFF_W-1:0] OFF_CIN_STAT  = 6'h14;
    localparam logic [OFF_W-1:0] OFF_COUT_DATA = 6'h18;
    localparam logic [OFF_W-1:0] OFF_COUT_STAT = 6'h1A;

    localparam logic [1:0] SZ_BYTE = 2'd0;

    typedef enum logic {ST_IDLE, ST_RESP} bus_state_e;
    typedef enum logic {HS_RUN, HS_HALTED} halt_state_e;
endpackage

// File: rtl/glue_bus_fsm.sv
module glue_bus_fsm
    import glue_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic accept,
    output logic ack
);
    bus_state_e st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state: T_ACCEPT and T_DONE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (req) st_d = ST_RESP;
            ST_RESP: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept = req && (st_q == ST_IDLE);
        ack    = (st_q == ST_RESP);
    end
endmodule

// File: rtl/glue_halt_fsm.sv
module glue_halt_fsm
    import glue_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic [7:0] code_in,
    output logic       halt_req,
    output logic [7:0] halt_code
);
    halt_state_e st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HS_RUN;
        else        st_q <= st_d;
    end

    // next state: T_HALT, HS_HALTED is terminal
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HS_RUN:    if (hit) st_d = HS_HALTED;
            HS_HALTED: st_d = HS_HALTED;
        endcase
    end

    // outputs: exit code captured only on T_HALT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        halt_code <= '0;
        else if (st_q == HS_RUN && hit)    halt_code <= code_in;
    end

    assign halt_req = (st_q == HS_HALTED);
endmodule

// File: rtl/glue_irq_bank.sv
module glue_irq_bank #(
    parameter int NUM_IRQ = 4,
    parameter int LVL_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hit,
    input  logic [7:0]                    line_sel,
    input  logic [LVL_W-1:0]              level,
    output logic [NUM_IRQ-1:0][LVL_W-1:0] irq_level
);
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                irq_level[i] <= '0;
            else if (hit && (line_sel == 8'(i)))       irq_level[i] <= level;
        end
    end
endmodule

// File: rtl/glue_console.sv
module glue_console
    import glue_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             wr,
    input  logic [OFF_W-1:0] off,
    input  logic [7:0]       wbyte,
    input  logic             cin_ready,
    input  logic [7:0]       cin_char,
    output logic [7:0]       cin_data,
    output logic [7:0]       cout_data,
    output logic [7:0]       cout_stat,
    output logic             cout_valid,
    output logic             cin_pop
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cin_data   <= '0;
            cout_data  <= '0;
            cout_stat  <= 8'h01;
            cout_valid <= 1'b0;
            cin_pop    <= 1'b0;
        end else begin
            cout_valid <= 1'b0;
            cin_pop    <= 1'b0;
            if (accept && wr) begin
                case (off)
                    OFF_CIN_DATA:  cin_data <= wbyte;
                    OFF_COUT_DATA: begin
                        cout_data  <= wbyte;
                        cout_stat  <= 8'h01;
                        cout_valid <= 1'b1;
                    end
                    OFF_COUT_STAT: cout_stat <= wbyte;
                    default: ;
                endcase
            end else if (accept && off == OFF_CIN_STAT) begin
                if (cin_ready) begin
                    cin_data <= cin_char;
                    cin_pop  <= 1'b1;
                end else begin
                    cin_data <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/glue_regs_top.sv
module glue_regs_top
    import glue_pkg::*;
#(
    parameter int NUM_IRQ = 4,
    parameter int CPU_W   = 2,
    parameter int ADDR_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_valid,
    input  logic                      bus_write,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [1:0]                bus_size,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic [CPU_W-1:0]          bus_cpu_idx,
    output logic                      bus_ack,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic                      cfg_count_valid,
    input  logic [CPU_W:0]            cfg_cpu_count,
    input  logic                      cin_ready,
    input  logic [7:0]                cin_char,
    output logic                      cin_pop,
    output logic                      cout_valid,
    output logic [7:0]                cout_char,
    output logic                      halt_req,
    output logic [7:0]                halt_code,
    output logic [NUM_IRQ-1:0][7:0]   irq_level
);
    logic             accept;
    logic [OFF_W-1:0] off;
    logic             wr_acc;
    logic [7:0]       cin_data, cout_data, cout_stat;
    logic [7:0]       irq_lvl;
    logic [DATA_W-1:0] rd_mux;
    logic             addr_unused;

    assign off         = bus_addr[OFF_W-1:0];
    assign addr_unused = ^{bus_addr[ADDR_W-1:OFF_W], bus_wdata[DATA_W-1:16]};
    assign wr_acc      = accept && bus_write;
    assign irq_lvl     = (bus_size == SZ_BYTE) ? 8'h00 : bus_wdata[15:8];

    glue_bus_fsm u_bus (
        .clk(clk), .rst_n(rst_n), .req(bus_valid),
        .accept(accept), .ack(bus_ack)
    );

    glue_halt_fsm u_halt (
        .clk(clk), .rst_n(rst_n),
        .hit(wr_acc && off == OFF_HALT), .code_in(bus_wdata[7:0]),
        .halt_req(halt_req), .halt_code(halt_code)
    );

    glue_irq_bank #(.NUM_IRQ(NUM_IRQ), .LVL_W(8)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .hit(wr_acc && off == OFF_IRQ), .line_sel(bus_wdata[7:0]),
        .level(irq_lvl), .irq_level(irq_level)
    );

    glue_console u_con (
        .clk(clk), .rst_n(rst_n), .accept(accept), .wr(bus_write),
        .off(off), .wbyte(bus_wdata[7:0]),
        .cin_ready(cin_ready), .cin_char(cin_char),
        .cin_data(cin_data), .cout_data(cout_data), .cout_stat(cout_stat),
        .cout_valid(cout_valid), .cin_pop(cin_pop)
    );

    assign cout_char = cout_data;

    always_comb begin
        case (off)
            OFF_CPU_IDX:   rd_mux = DATA_W'(bus_cpu_idx);
            OFF_CPU_CNT:   rd_mux = cfg_count_valid ? DATA_W'(cfg_cpu_count) : DATA_W'(1);
            OFF_CIN_DATA:  rd_mux = DATA_W'(cin_data);
            OFF_CIN_STAT:  rd_mux = DATA_W'(cin_ready);
            OFF_COUT_DATA: rd_mux = DATA_W'(cout_data);
            OFF_COUT_STAT: rd_mux = DATA_W'(cout_stat);
            default:       rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (accept) bus_rdata <= bus_write ? '0 : rd_mux;
    end
endmodule

// File: rtl/glue_regs_chk.sv
module glue_regs_chk #(
    parameter int NUM_IRQ = 4,
    parameter int ADDR_W  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_valid,
    input logic                    bus_write,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [31:0]             bus_wdata,
    input logic                    bus_ack,
    input logic                    cin_ready,
    input logic                    cin_pop,
    input logic                    cout_valid,
    input logic [7:0]              cout_char,
    input logic                    halt_req,
    input logic [7:0]              halt_code,
    input logic [NUM_IRQ-1:0][7:0] irq_level
);
    logic       chk_unused;
    logic       take;
    logic [5:0] o;

    assign chk_unused = ^{bus_addr[ADDR_W-1:6], bus_wdata[31:8]};
    assign take       = bus_valid && !bus_ack;
    assign o          = bus_addr[5:0];

    a_r2_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> bus_ack);
    a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
    a_r4_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> (halt_req && $stable(halt_code)));
    a_r9_cout_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        cout_valid |-> $past(take && bus_write && o == 6'h18));
    a_r9_cout_char: assert property (@(posedge clk) disable iff (!rst_n)
        cout_valid |-> (cout_char == $past(bus_wdata[7:0])));
    a_r7_irq_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_level) |-> $past(take && bus_write && o == 6'h08));
    a_r8_pop_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cin_pop |-> $past(take && !bus_write && o == 6'h14 && cin_ready));
endmodule

bind glue_regs_top glue_regs_chk #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .cin_ready(cin_ready), .cin_pop(cin_pop), .cout_valid(cout_valid),
    .cout_char(cout_char), .halt_req(halt_req), .halt_code(halt_code),
    .irq_level(irq_level)
);

// File: tb/glue_regs_top_tb_top.sv
module glue_regs_top_tb_top;
    localparam int NUM_IRQ = 4;
    localparam int CPU_W   = 2;
    localparam int ADDR_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 0, bus_write = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [1:0] bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [CPU_W-1:0] bus_cpu_idx = '0;
    logic bus_ack;
    logic [31:0] bus_rdata;
    logic cfg_count_valid = 0;
    logic [CPU_W:0] cfg_cpu_count = '0;
    logic cin_ready = 0;
    logic [7:0] cin_char = '0;
    logic cin_pop, cout_valid, halt_req;
    logic [7:0] cout_char, halt_code;
    logic [NUM_IRQ-1:0][7:0] irq_level;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        bit          rd;
        logic [31:0] exp;
        string       req;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    glue_regs_top #(.NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W), .ADDR_W(ADDR_W)) dut_i (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: pushes the expected item, returns on the ack cycle negedge
    task automatic access(bit wr, logic [15:0] addr, logic [1:0] sz,
                          logic [31:0] wd, logic [31:0] exp, string req);
        sb_q.push_back('{rd: !wr, exp: exp, req: req});
        @(negedge clk);
        bus_valid = 1; bus_write = wr; bus_addr = addr; bus_size = sz; bus_wdata = wd;
        @(negedge clk);
        bus_valid = 0;
    endtask

    // monitor: pops and compares on every ack
    always @(negedge clk) begin
        if (rst_n && bus_ack) begin
            if (sb_q.size() == 0) begin
                chk("R2 unexpected ack", 32'd1, 32'd0);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (it.rd) chk(it.req, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ack", 32'(bus_ack), 0);
        chk("R1 halt", 32'(halt_req), 0);
        chk("R1 irq", 32'(irq_level), 0);
        chk("R1 cout_valid", 32'(cout_valid), 0);
        chk("R1 cin_pop", 32'(cin_pop), 0);
        access(0, 16'h001A, 0, 0, 32'd1, "R1 out status");
        access(0, 16'h0010, 0, 0, 32'd0, "R1 in data");

        // R5 processor index
        bus_cpu_idx = 2'd2;
        access(0, 16'h0004, 2, 0, 32'd2, "R5 idx 2");
        bus_cpu_idx = 2'd1;
        access(0, 16'h0004, 2, 0, 32'd1, "R5 idx 1");

        // R6 processor count
        access(0, 16'h000A, 0, 0, 32'd1, "R6 default count");
        cfg_count_valid = 1; cfg_cpu_count = 3'd3;
        access(0, 16'h000A, 0, 0, 32'd3, "R6 configured count");
        // R3 alias
        access(0, 16'h004A, 0, 0, 32'd3, "R3 alias count");

        // R7 interrupt lines
        access(1, 16'h0008, 1, 32'h0502, 0, "R7");
        chk("R7 line2 half", 32'(irq_level[2]), 32'h05);
        access(1, 16'h0008, 2, 32'h0701, 0, "R7");
        chk("R7 line1 word", 32'(irq_level[1]), 32'h07);
        chk("R7 line2 holds", 32'(irq_level[2]), 32'h05);
        access(1, 16'h0008, 0, 32'h0902, 0, "R7");
        chk("R7 byte size level 0", 32'(irq_level[2]), 32'h00);
        access(1, 16'h0008, 1, 32'h0309, 0, "R7");
        chk("R7 out of range ignored", 32'(irq_level), 32'h0000_0700);
        access(1, 16'h0048, 1, 32'h0403, 0, "R3");
        chk("R3 alias irq", 32'(irq_level[3]), 32'h04);

        // R8 console input sampling
        cin_ready = 1; cin_char = 8'h41;
        access(0, 16'h0014, 0, 0, 32'd1, "R8 status ready");
        chk("R8 pop", 32'(cin_pop), 1);
        cin_ready = 0;
        access(0, 16'h0010, 0, 0, 32'h41, "R8 data loaded");
        chk("R8 no pop on data read", 32'(cin_pop), 0);
        access(0, 16'h0014, 0, 0, 32'd0, "R8 status empty");
        chk("R8 no pop", 32'(cin_pop), 0);
        access(0, 16'h0010, 0, 0, 32'd0, "R8 data cleared");

        // R10 direct writes
        access(1, 16'h0010, 0, 32'h33, 0, "R10");
        access(0, 16'h0010, 0, 0, 32'h33, "R10 in data readback");
        access(1, 16'h001A, 0, 32'h00, 0, "R10");
        access(0, 16'h001A, 0, 0, 32'h00, "R10 out status readback");

        // R9 console output
        access(1, 16'h0018, 0, 32'h5A, 0, "R9");
        chk("R9 strobe", 32'(cout_valid), 1);
        chk("R9 char", 32'(cout_char), 32'h5A);
        @(negedge clk);
        chk("R9 strobe one cycle", 32'(cout_valid), 0);
        access(0, 16'h0018, 0, 0, 32'h5A, "R9 data readback");
        access(0, 16'h001A, 0, 0, 32'h01, "R9 status set");

        // R11 unmapped and write-only offsets
        access(0, 16'h000C, 2, 0, 32'd0, "R11 unmapped read");
        access(0, 16'h0008, 2, 0, 32'd0, "R11 irq reads zero");
        access(0, 16'h0000, 2, 0, 32'd0, "R11 halt reads zero");
        access(1, 16'h000C, 2, 32'hFFFF_FF02, 0, "R11");
        access(1, 16'h003E, 2, 32'hFFFF_FF01, 0, "R11");
        chk("R11 irq untouched", 32'(irq_level), 32'h0400_0700);
        chk("R11 halt untouched", 32'(halt_req), 0);
        access(0, 16'h0018, 0, 0, 32'h5A, "R11 out data untouched");

        // R2 held request during ack is ignored
        sb_q.push_back('{rd: 0, exp: 0, req: "R2"});
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 16'h0018; bus_wdata = 32'h77;
        @(negedge clk);
        chk("R2 ack", 32'(bus_ack), 1);
        @(negedge clk);
        bus_valid = 0;
        chk("R2 held ignored ack", 32'(bus_ack), 0);
        chk("R2 held ignored strobe", 32'(cout_valid), 0);

        // R4 halt
        access(1, 16'h0000, 0, 32'h2A, 0, "R4");
        chk("R4 halt set", 32'(halt_req), 1);
        chk("R4 code", 32'(halt_code), 32'h2A);
        access(1, 16'h0040, 0, 32'h11, 0, "R4");
        chk("R4 sticky", 32'(halt_req), 1);
        chk("R4 code kept", 32'(halt_code), 32'h2A);

        repeat (2) @(negedge clk);
        chk("R2 scoreboard drained", 32'(sb_q.size()), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule